// File: doc/BRIEF.md
# Interleaved I/Q Parallel Input Assembler

This block is the front end of a quadrature transmit path. It takes signed
two's-complement words from one parallel port and sorts them into an I stream
and a Q stream for the filters downstream. It paces the word source by putting
out a one-cycle data-clock enable, derived from the system clock by a
programmable divider. That enable can be held off until an external lock
indication is good. A word is captured on the system clock edge at which the
enable is high.

In quadrature mode, words arrive alternately as I and Q. An I/Q pair is issued
as one sample only once both halves are in, so samples come out at half the
word rate. In interpolating mode, every word goes to the I path and Q stays at
zero. A transmit-enable input frames bursts, and its rising edge makes the next
captured word an I word. While the enable is low, port data is ignored and
zero samples are pushed down both paths to flush them.

Top module: `iq_input_assembler`

## Requirements
- R1: After reset, valid_o is low and i_o and q_o are zero.
- R2: With the gate open, dclk_o is high for exactly one cycle in every div_i+1 system clock cycles. The first pulse comes in cycle div_i after reset, and div_i=0 gives a pulse every cycle.
- R3: While lock_gate_i is 1 and lock_ok_i is 0, dclk_o stays low and no word is captured. The divider keeps counting while the gate is closed.
- R4: In quadrature mode (quad_mode_i=1), the first word captured after tx_en_i rises is taken as I. The word captured next is taken as Q. On the edge that captures Q, the pair is issued: in the following cycle valid_o is 1, i_o holds the I word and q_o holds the Q word, both unchanged.
- R5: While tx_en_i stays high in quadrature mode, captured words keep alternating I, Q, I, Q, and one pair is issued per two captures.
- R6: While tx_en_i is low, data_i is ignored and zero samples are issued instead. In quadrature mode a zero pair comes out on every second data-clock enable. In interpolating mode one comes out on every enable.
- R7: If a burst ends after an I word without its Q word, that I word is dropped and never appears on i_o.
- R8: In interpolating mode (quad_mode_i=0), every captured word is issued at once with valid_o, with i_o equal to the word and q_o equal to zero.
- R9: valid_o is a one-cycle pulse per issued sample, and i_o and q_o hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| quad_mode_i | input | 1 | 1 = interleaved quadrature, 0 = interpolating (I only) |
| div_i | input | DIV_W (8) | Data-clock period minus one, in system cycles |
| lock_gate_i | input | 1 | 1 = hold data clock off until lock_ok_i |
| lock_ok_i | input | 1 | Clock-lock good indication |
| tx_en_i | input | 1 | Burst framing enable |
| data_i | input | DATA_W (14) | Two's-complement input word |
| dclk_o | output | 1 | Data-clock enable, also the capture strobe |
| i_o | output | DATA_W (14) | I sample |
| q_o | output | DATA_W (14) | Q sample |
| valid_o | output | 1 | One-cycle pulse per issued sample |

## Verification
Random traffic draws the divider setting, the lock gate, the mode, the word
values and the enable as independent variables. Short enable bursts make odd
word counts happen often, so the pairing order and the dropping of unpaired I
words are both exercised. Enable rises that land on a capture edge check that
phase is forced back to I. Rises that land between capture edges check that the
framing event is remembered until the next capture. Directed runs cover div_i=0,
an odd burst, interpolating mode, and a closed lock gate, with known words, so
that a swapped I/Q order, a missing flush or a leaked word each give a distinct
mismatch.

// File: rtl/iq_asm_pkg.sv
package iq_asm_pkg;
  localparam int unsigned DATA_W = 14;
  localparam int unsigned DIV_W  = 8;
  typedef enum logic {PH_I = 1'b0, PH_Q = 1'b1} phase_e;
endpackage

// File: rtl/iq_dclk_gen.sv
module iq_dclk_gen #(
  parameter int unsigned DIV_W = iq_asm_pkg::DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             lock_gate_i,
  input  logic             lock_ok_i,
  output logic             dclk_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick   = (cnt_q >= div_i);
  assign dclk_o = tick & (~lock_gate_i | lock_ok_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R2: isolated pulse unless the period is a single cycle
  p_pulse_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dclk_o && div_i != '0) |=> (div_i == '0 || !dclk_o));
endmodule

// File: rtl/iq_pair_demux.sv
module iq_pair_demux
  import iq_asm_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         quad_i,
  input  logic         strobe_i,
  input  logic         tx_en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] i_o,
  output logic [W-1:0] q_o,
  output logic         valid_o
);
  phase_e       ph_q;
  logic         tx_d_q, arm_q;
  logic [W-1:0] hold_q;
  logic         rise;

  assign rise = tx_en_i & ~tx_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_I;
      tx_d_q  <= 1'b0;
      arm_q   <= 1'b0;
      hold_q  <= '0;
      i_o     <= '0;
      q_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      tx_d_q  <= tx_en_i;
      valid_o <= 1'b0;
      if (strobe_i)  arm_q <= 1'b0;
      else if (rise) arm_q <= 1'b1;
      if (strobe_i) begin
        if (tx_en_i) begin
          if (!quad_i) begin
            i_o     <= data_i;
            q_o     <= '0;
            valid_o <= 1'b1;
            ph_q    <= PH_I;
          end else if (arm_q || rise || ph_q == PH_I) begin
            // burst start or I slot
            hold_q <= data_i;
            ph_q   <= PH_Q;
          end else begin
            i_o     <= hold_q;
            q_o     <= data_i;
            valid_o <= 1'b1;
            ph_q    <= PH_I;
          end
        end else begin
          // flush: drop any unpaired I, emit zeros at sample rate
          hold_q <= '0;
          if (!quad_i || ph_q == PH_Q) begin
            i_o     <= '0;
            q_o     <= '0;
            valid_o <= 1'b1;
            ph_q    <= PH_I;
          end else begin
            ph_q <= PH_Q;
          end
        end
      end
    end
  end

  // R9: outputs hold between pulses
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(i_o) && $stable(q_o)));
  // R6: samples issued while disabled are zero
  p_flush_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(tx_en_i)) |-> (i_o == '0 && q_o == '0));
  // R8: Q idle in interpolating mode
  p_q_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(quad_i)) |-> (q_o == '0));
endmodule

// File: rtl/iq_input_assembler.sv
module iq_input_assembler
  import iq_asm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned DV = DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          quad_mode_i,
  input  logic [DV-1:0] div_i,
  input  logic          lock_gate_i,
  input  logic          lock_ok_i,
  input  logic          tx_en_i,
  input  logic [DW-1:0] data_i,
  output logic          dclk_o,
  output logic [DW-1:0] i_o,
  output logic [DW-1:0] q_o,
  output logic          valid_o
);
  logic strobe;

  iq_dclk_gen #(.DIV_W(DV)) u_dclk (
    .clk_i, .rst_ni, .div_i, .lock_gate_i, .lock_ok_i, .dclk_o(strobe)
  );

  iq_pair_demux #(.W(DW)) u_demux (
    .clk_i, .rst_ni, .quad_i(quad_mode_i), .strobe_i(strobe),
    .tx_en_i, .data_i, .i_o, .q_o, .valid_o
  );

  assign dclk_o = strobe;

  // R3: no sample without a preceding capture strobe
  p_valid_after_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(strobe));
  // R3: closed gate suppresses the strobe
  p_gate_closed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_gate_i && !lock_ok_i) |-> !dclk_o);
endmodule

// File: tb/iq_input_assembler_bench.sv
module iq_input_assembler_bench;
  localparam int DW = 14;
  localparam int DV = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          quad = 1'b1, gate = 1'b0, ok = 1'b0, tx = 1'b0;
  logic [DV-1:0] div = '0;
  logic [DW-1:0] data = '0;
  logic          dclk, valid;
  logic [DW-1:0] i_s, q_s;

  always #10 clk = ~clk;

  iq_input_assembler u_iq_input_assembler (
    .clk_i(clk), .rst_ni(rst_n), .quad_mode_i(quad), .div_i(div),
    .lock_gate_i(gate), .lock_ok_i(ok), .tx_en_i(tx), .data_i(data),
    .dclk_o(dclk), .i_o(i_s), .q_o(q_s), .valid_o(valid)
  );

  int n_chk = 0, n_bad = 0;
  int seen_pairs = 0;

  // reference model state
  logic [DV-1:0] m_cnt;
  logic          m_ph, m_arm, m_txd;
  logic          e_valid;
  logic [DW-1:0] m_hold, e_i, e_q;

  task automatic chk(input logic ok_c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok_c) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic pred_dclk();
    return (m_cnt >= div) && (!gate || ok);
  endfunction

  task automatic model_edge();
    logic tick, strb, rise;
    tick = (m_cnt >= div);
    strb = tick && (!gate || ok);
    rise = tx && !m_txd;
    e_valid = 1'b0;
    if (strb) begin
      if (tx) begin
        if (!quad) begin
          e_i = data; e_q = '0; e_valid = 1'b1; m_ph = 1'b0;
        end else if (m_arm || rise || !m_ph) begin
          m_hold = data; m_ph = 1'b1;
        end else begin
          e_i = m_hold; e_q = data; e_valid = 1'b1; m_ph = 1'b0;
        end
      end else begin
        m_hold = '0;
        if (!quad || m_ph) begin
          e_i = '0; e_q = '0; e_valid = 1'b1; m_ph = 1'b0;
        end else m_ph = 1'b1;
      end
    end
    if (strb) m_arm = 1'b0; else if (rise) m_arm = 1'b1;
    m_cnt = tick ? '0 : m_cnt + 1'b1;
    m_txd = tx;
  endtask

  // one system cycle: current inputs taken by the edge, then outputs compared
  task automatic cycle();
    string tag;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (!e_valid) tag = "R9";
    else if (!m_txd) tag = "R6";
    else if (!quad) tag = "R8";
    else tag = "R4";
    chk(valid == e_valid, {tag, " valid"}, 32'(valid), 32'(e_valid));
    chk(i_s == e_i, {tag, " i"}, 32'(i_s), 32'(e_i));
    chk(q_s == e_q, {tag, " q"}, 32'(q_s), 32'(e_q));
    if (valid && quad && m_txd) seen_pairs++;
  endtask

  task automatic check_dclk();
    #1;
    chk(dclk == pred_dclk(), (gate && !ok) ? "R3 dclk" : "R2 dclk",
        32'(dclk), 32'(pred_dclk()));
  endtask

  // drive a word and wait until it is captured
  task automatic put_word(input logic [DW-1:0] w);
    data = w;
    check_dclk();
    while (!dclk) begin cycle(); check_dclk(); end
    cycle();
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_cnt = '0; m_ph = 1'b0; m_arm = 1'b0; m_txd = 1'b0;
    m_hold = '0; e_i = '0; e_q = '0; e_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(valid == 1'b0, "R1 valid", 32'(valid), 0);
    chk(i_s == '0, "R1 i", 32'(i_s), 0);
    chk(q_s == '0, "R1 q", 32'(q_s), 0);
    rst_n = 1'b1;

    // R2 directed: div=2, first pulse in cycle 2
    div = 8'd2;
    check_dclk(); chk(dclk == 1'b0, "R2 first0", 32'(dclk), 0); cycle();
    check_dclk(); chk(dclk == 1'b0, "R2 first1", 32'(dclk), 0); cycle();
    check_dclk(); chk(dclk == 1'b1, "R2 first2", 32'(dclk), 1); cycle();

    // R4/R5 directed quad burst at div=0
    div = '0; quad = 1'b1;
    put_word(14'h0AAA); put_word(14'h0AAA);
    tx = 1'b1;
    put_word(14'h2ABC);
    put_word(14'h0123);
    chk(valid && i_s == 14'h2ABC && q_s == 14'h0123, "R4 pair",
        {i_s, q_s}, {14'h2ABC, 14'h0123});
    put_word(14'h1111);
    put_word(14'h3FFF);
    chk(valid && i_s == 14'h1111 && q_s == 14'h3FFF, "R5 second pair",
        {i_s, q_s}, {14'h1111, 14'h3FFF});
    // R7: odd burst, unpaired I dropped
    put_word(14'h1555);
    tx = 1'b0;
    put_word(14'h0777);
    chk(valid && i_s == '0 && q_s == '0, "R7 dropped I", 32'(i_s), 0);
    put_word(14'h0777);
    chk(!valid && i_s == '0, "R6 flush pace", 32'(valid), 0);

    // R8 directed interpolating mode
    quad = 1'b0; tx = 1'b1;
    put_word(14'h2001);
    chk(valid && i_s == 14'h2001 && q_s == '0, "R8 word", 32'(i_s), 32'h2001);

    // R3 directed: gate closed, no strobe, nothing issued
    gate = 1'b1; ok = 1'b0; data = 14'h0F0F;
    for (int k = 0; k < 8; k++) begin
      check_dclk();
      chk(dclk == 1'b0, "R3 closed", 32'(dclk), 0);
      cycle();
      chk(valid == 1'b0, "R3 no sample", 32'(valid), 0);
    end
    ok = 1'b1;

    // random traffic
    quad = 1'b1;
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(0, 199) == 0) div = DV'($urandom_range(0, 3));
      if ($urandom_range(0, 299) == 0) quad = ~quad;
      if ($urandom_range(0, 99) == 0) gate = ~gate;
      if ($urandom_range(0, 29) == 0) ok = ~ok;
      if ($urandom_range(0, 11) == 0) tx = ~tx;
      data = DW'($urandom);
      check_dclk();
      cycle();
    end
    chk(seen_pairs > 20, "R5 pairs seen", 32'(seen_pairs), 21);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule